// File: doc/BRIEF.md
# LIN Controller Status and Event Flags

This block holds the status word of a LIN bus controller. The frame engine, bit timer and data buffer live elsewhere. They send single-cycle event pulses here, and the block turns each pulse into a sticky flag when the conditions around it allow. A receive completion is dropped when the frame carries a bit error or a framing error. A transmit completion is dropped after a bit error unless the ignore-bit-error control is set. The buffer-full and buffer-empty flags count only for long frames. A wake-up needs a falling edge on the receive pin while the node is in a suitable mode.

Software reads the status word over a small register bus and clears flags by writing ones. A second register holds one interrupt enable for each flag. The registered interrupt line goes high when any enabled flag is set. The status word also shows two live bits: receiver busy, and the synchronized level of the receive pin. While initialization mode is active, every flag is held at zero. When software clears a set buffer-empty flag, the block emits a one-cycle resume pulse that tells the frame engine it may keep transmitting.

Register map: address 0 is the status word (read, write-one-to-clear). Address 1 is the enable register (read/write, bits 5:0). Status bit positions are: 0 receive done, 1 transmit done, 2 buffer full, 3 buffer empty, 4 wake-up, 5 message ready, 6 receiver busy (read-only), 7 pin level (read-only). Enable bit n gates status bit n.

Top module: `lin_status_flags`

## Requirements
- R1: After reset, every flag, enable bit, the interrupt and the resume pulse are 0. With the pin high and receiver busy low, a status read returns 0x80.
- R2: A write to address 0 clears exactly the flags whose data bits are 1. Flags written with 0 keep their value.
- R3: When a flag's set condition and its software clear fall in the same cycle, the flag ends up set.
- R4: While initialization mode is high, all six flags read 0 from the next edge on, even when set events arrive.
- R5: The receive-done flag (bit 0) is set by a receive completion pulse only when neither bit error nor framing error is high in that cycle.
- R6: The transmit-done flag (bit 1) is set by a transmit completion pulse unless bit error is high in that cycle and ignore-bit-error is low.
- R7: The buffer-full (bit 2) and buffer-empty (bit 3) events set their flags only when the data field length code is 8 or more. A code of 7 or less has no effect.
- R8: A write that clears a set buffer-empty flag, with no new buffer-empty set in that cycle, gives a resume pulse that is high for exactly one cycle after that edge.
- R9: The wake-up flag (bit 4) is set by a falling edge of the synchronized pin when the node is a slave in sleep, or a master in sleep or idle. Otherwise the edge is ignored. The flag appears three edges after the pin falls.
- R10: Status bit 7 shows the receive pin through a two-flop synchronizer, so it changes two edges after the pin. Status bit 6 follows the receiver-busy input in the same cycle.
- R11: Address 1 stores and returns the enables. The interrupt is the registered OR of all flags ANDed with their enables, one edge behind them.
- R12: A message-ready pulse sets status bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| init_mode_i | input | 1 | Initialization mode active |
| slave_mode_i | input | 1 | 1 = slave node, 0 = master node |
| sleep_i | input | 1 | Node is in sleep mode |
| master_idle_i | input | 1 | Master is in idle state |
| ev_rx_done_i | input | 1 | Receive completion pulse |
| ev_tx_done_i | input | 1 | Transmit completion pulse |
| ev_bit_err_i | input | 1 | Bit error in the current frame |
| ev_frame_err_i | input | 1 | Framing error in the current frame |
| ignore_bit_err_i | input | 1 | Ignore bit errors for transmit completion |
| ev_buf_full_i | input | 1 | Receive buffer full pulse |
| ev_buf_empty_i | input | 1 | Transmit buffer empty pulse |
| dfl_i | input | 4 | Data field length code of the frame |
| ev_msg_ready_i | input | 1 | Message buffer ready pulse |
| rx_busy_i | input | 1 | Live receiver busy status |
| rx_pin_i | input | 1 | Asynchronous LIN receive pin |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| irq_o | output | 1 | Registered interrupt |
| tx_resume_o | output | 1 | One-cycle pulse after buffer-empty is cleared |

## Verification
Each event is driven both alone and with every error or mode qualifier that should block it. This separates a flag that is really gated from one that only mirrors its pulse. Clears are tried with zero data, together with a set in the same cycle, and inside initialization mode, which exposes a wrong priority among set, clear and init. The length code is driven at 7, 8 and 15 to pin down the long-frame boundary. Wake-up edges are driven in slave-awake, slave-sleep, master-idle and master-active modes, and the pin is sampled edge by edge to check the synchronizer latency.

// File: rtl/lin_flag_pkg.sv
package lin_flag_pkg;
  localparam int NUM_FLAGS   = 6;
  localparam int F_RX_DONE   = 0;
  localparam int F_TX_DONE   = 1;
  localparam int F_BUF_FULL  = 2;
  localparam int F_BUF_EMPTY = 3;
  localparam int F_WAKE      = 4;
  localparam int F_MSG_RDY   = 5;
  localparam int STAT_BUSY   = 6;
  localparam int STAT_PIN    = 7;

  typedef logic [NUM_FLAGS-1:0] flag_vec_t;
endpackage

// File: rtl/lin_pin_sync.sv
module lin_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic level_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  // idle LIN bus is recessive high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign level_o = sync_q[STAGES-1];
  assign fall_o  = prev_q & ~level_o;
endmodule

// File: rtl/lin_flag_qual.sv
module lin_flag_qual
  import lin_flag_pkg::*;
#(
  parameter int DFL_W       = 4,
  parameter int EXT_DFL_MIN = 8
) (
  input  logic             ev_rx_done_i,
  input  logic             ev_tx_done_i,
  input  logic             ev_bit_err_i,
  input  logic             ev_frame_err_i,
  input  logic             ignore_bit_err_i,
  input  logic             ev_buf_full_i,
  input  logic             ev_buf_empty_i,
  input  logic [DFL_W-1:0] dfl_i,
  input  logic             ev_msg_ready_i,
  input  logic             slave_mode_i,
  input  logic             sleep_i,
  input  logic             master_idle_i,
  input  logic             pin_fall_i,
  output flag_vec_t        set_o
);
  logic long_frame;
  logic wake_armed;

  assign long_frame = (32'(dfl_i) >= EXT_DFL_MIN);
  assign wake_armed = slave_mode_i ? sleep_i : (sleep_i | master_idle_i);

  always_comb begin
    set_o              = '0;
    set_o[F_RX_DONE]   = ev_rx_done_i & ~ev_bit_err_i & ~ev_frame_err_i;
    set_o[F_TX_DONE]   = ev_tx_done_i & ~(ev_bit_err_i & ~ignore_bit_err_i);
    set_o[F_BUF_FULL]  = ev_buf_full_i & long_frame;
    set_o[F_BUF_EMPTY] = ev_buf_empty_i & long_frame;
    set_o[F_WAKE]      = pin_fall_i & wake_armed;
    set_o[F_MSG_RDY]   = ev_msg_ready_i;
  end
endmodule

// File: rtl/lin_flag_cell.sv
module lin_flag_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic init_i,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  // priority: init, then set, then software clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= 1'b0;
    else if (init_i) q_o <= 1'b0;
    else if (set_i)  q_o <= 1'b1;
    else if (clr_i)  q_o <= 1'b0;
  end
endmodule

// File: rtl/lin_status_flags.sv
module lin_status_flags
  import lin_flag_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DFL_W       = 4,
  parameter int EXT_DFL_MIN = 8,
  parameter int ADDR_W      = 2,
  parameter int DATA_W      = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_mode_i,
  input  logic              slave_mode_i,
  input  logic              sleep_i,
  input  logic              master_idle_i,
  input  logic              ev_rx_done_i,
  input  logic              ev_tx_done_i,
  input  logic              ev_bit_err_i,
  input  logic              ev_frame_err_i,
  input  logic              ignore_bit_err_i,
  input  logic              ev_buf_full_i,
  input  logic              ev_buf_empty_i,
  input  logic [DFL_W-1:0]  dfl_i,
  input  logic              ev_msg_ready_i,
  input  logic              rx_busy_i,
  input  logic              rx_pin_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o,
  output logic              tx_resume_o
);
  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] EN_ADDR   = ADDR_W'(1);

  flag_vec_t flag_q, flag_set, flag_clr, en_q;
  logic      pin_level, pin_fall;
  logic      stat_wr, en_wr;

  assign stat_wr = reg_we_i & (reg_addr_i == STAT_ADDR);
  assign en_wr   = reg_we_i & (reg_addr_i == EN_ADDR);

  lin_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pin_i   (rx_pin_i),
    .level_o (pin_level),
    .fall_o  (pin_fall)
  );

  lin_flag_qual #(.DFL_W(DFL_W), .EXT_DFL_MIN(EXT_DFL_MIN)) u_qual (
    .ev_rx_done_i     (ev_rx_done_i),
    .ev_tx_done_i     (ev_tx_done_i),
    .ev_bit_err_i     (ev_bit_err_i),
    .ev_frame_err_i   (ev_frame_err_i),
    .ignore_bit_err_i (ignore_bit_err_i),
    .ev_buf_full_i    (ev_buf_full_i),
    .ev_buf_empty_i   (ev_buf_empty_i),
    .dfl_i            (dfl_i),
    .ev_msg_ready_i   (ev_msg_ready_i),
    .slave_mode_i     (slave_mode_i),
    .sleep_i          (sleep_i),
    .master_idle_i    (master_idle_i),
    .pin_fall_i       (pin_fall),
    .set_o            (flag_set)
  );

  assign flag_clr = stat_wr ? reg_wdata_i[NUM_FLAGS-1:0] : '0;

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    lin_flag_cell u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .init_i (init_mode_i),
      .set_i  (flag_set[g]),
      .clr_i  (flag_clr[g]),
      .q_o    (flag_q[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q        <= '0;
      irq_o       <= 1'b0;
      tx_resume_o <= 1'b0;
    end else begin
      if (en_wr) en_q <= reg_wdata_i[NUM_FLAGS-1:0];
      irq_o       <= |(flag_q & en_q);
      // frame engine may refill-continue once software drops buffer-empty
      tx_resume_o <= ~init_mode_i & flag_q[F_BUF_EMPTY] & flag_clr[F_BUF_EMPTY]
                     & ~flag_set[F_BUF_EMPTY];
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == EN_ADDR) begin
      reg_rdata_o[NUM_FLAGS-1:0] = en_q;
    end else if (reg_addr_i == STAT_ADDR) begin
      reg_rdata_o[NUM_FLAGS-1:0] = flag_q;
      reg_rdata_o[STAT_BUSY]     = rx_busy_i;
      reg_rdata_o[STAT_PIN]      = pin_level;
    end
  end
endmodule

// File: rtl/lin_status_flags_chk.sv
module lin_status_flags_chk
  import lin_flag_pkg::*;
#(
  parameter int DFL_W       = 4,
  parameter int EXT_DFL_MIN = 8,
  parameter int ADDR_W      = 2,
  parameter int DATA_W      = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              init_mode_i,
  input logic              ev_rx_done_i,
  input logic              ev_bit_err_i,
  input logic              ev_frame_err_i,
  input logic              ev_buf_full_i,
  input logic [DFL_W-1:0]  dfl_i,
  input logic              ev_msg_ready_i,
  input logic              reg_we_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input flag_vec_t         flag_q,
  input flag_vec_t         en_q,
  input logic              irq_o,
  input logic              tx_resume_o
);
  a_r4_init_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_mode_i |=> (flag_q == '0));

  a_r3_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!init_mode_i && ev_msg_ready_i) |=> flag_q[F_MSG_RDY]);

  a_r2_w1c_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ev_msg_ready_i && reg_we_i && reg_addr_i == ADDR_W'(0) && reg_wdata_i[F_MSG_RDY])
    |=> !flag_q[F_MSG_RDY]);

  a_r5_err_blocks_rx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_rx_done_i && (ev_bit_err_i || ev_frame_err_i) && !flag_q[F_RX_DONE])
    |=> !flag_q[F_RX_DONE]);

  a_r7_short_no_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_buf_full_i && 32'(dfl_i) < EXT_DFL_MIN && !flag_q[F_BUF_FULL])
    |=> !flag_q[F_BUF_FULL]);

  a_r11_irq_registered: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_o == $past(|(flag_q & en_q))));

  a_r8_resume_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_resume_o |=> !tx_resume_o);
endmodule

bind lin_status_flags lin_status_flags_chk #(
  .DFL_W(DFL_W), .EXT_DFL_MIN(EXT_DFL_MIN), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .init_mode_i    (init_mode_i),
  .ev_rx_done_i   (ev_rx_done_i),
  .ev_bit_err_i   (ev_bit_err_i),
  .ev_frame_err_i (ev_frame_err_i),
  .ev_buf_full_i  (ev_buf_full_i),
  .dfl_i          (dfl_i),
  .ev_msg_ready_i (ev_msg_ready_i),
  .reg_we_i       (reg_we_i),
  .reg_addr_i     (reg_addr_i),
  .reg_wdata_i    (reg_wdata_i),
  .flag_q         (flag_q),
  .en_q           (en_q),
  .irq_o          (irq_o),
  .tx_resume_o    (tx_resume_o)
);

// File: tb/sim_lin_status_flags.sv
`timescale 1ns/1ps
module sim_lin_status_flags;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       init_mode_i = 0, slave_mode_i = 0, sleep_i = 0, master_idle_i = 0;
  logic       ev_rx_done_i = 0, ev_tx_done_i = 0, ev_bit_err_i = 0, ev_frame_err_i = 0;
  logic       ignore_bit_err_i = 0, ev_buf_full_i = 0, ev_buf_empty_i = 0;
  logic [3:0] dfl_i = 0;
  logic       ev_msg_ready_i = 0, rx_busy_i = 0, rx_pin_i = 1;
  logic       reg_we_i = 0;
  logic [1:0] reg_addr_i = 0;
  logic [7:0] reg_wdata_i = 0;
  logic [7:0] reg_rdata_o;
  logic       irq_o, tx_resume_o;

  int n_chk = 0, n_err = 0, cyc_cnt = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  lin_status_flags u0 (.*);

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit [5:0] m_flags, m_en;
  bit       m_irq, m_resume;
  bit       pin_hist[$];

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_flags = 0; m_en = 0; m_irq = 0; m_resume = 0;
      pin_hist = '{1'b1, 1'b1, 1'b1};
    end else begin
      bit [5:0] s, c;
      bit fall, armed, longf;
      fall  = pin_hist[2] && !pin_hist[1];
      armed = slave_mode_i ? sleep_i : (sleep_i || master_idle_i);
      longf = (dfl_i > 7);
      s[0] = ev_rx_done_i && !ev_bit_err_i && !ev_frame_err_i;
      s[1] = ev_tx_done_i && !(ev_bit_err_i && !ignore_bit_err_i);
      s[2] = ev_buf_full_i && longf;
      s[3] = ev_buf_empty_i && longf;
      s[4] = fall && armed;
      s[5] = ev_msg_ready_i;
      c = (reg_we_i && reg_addr_i == 0) ? reg_wdata_i[5:0] : 6'd0;
      m_irq    = |(m_flags & m_en);
      m_resume = !init_mode_i && c[3] && m_flags[3] && !s[3];
      if (init_mode_i) m_flags = 0;
      else m_flags = s | (m_flags & ~c);
      if (reg_we_i && reg_addr_i == 1) m_en = reg_wdata_i[5:0];
      pin_hist.push_front(rx_pin_i);
      void'(pin_hist.pop_back());
    end
  end

  function automatic string req_of(int b);
    case (b)
      0: return "R5"; 1: return "R6"; 2, 3: return "R7";
      4: return "R9"; 5: return "R12"; default: return "R10";
    endcase
  endfunction

  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      logic [7:0] exp_rd;
      exp_rd = (reg_addr_i == 1) ? {2'b00, m_en}
             : (reg_addr_i == 0) ? {pin_hist[1], rx_busy_i, m_flags} : 8'h00;
      if (reg_rdata_o !== exp_rd) begin
        int fb = 0;
        for (int i = 7; i >= 0; i--) if (reg_rdata_o[i] !== exp_rd[i]) fb = i;
        check(reg_addr_i == 1 ? "R11" : req_of(fb), reg_rdata_o, exp_rd);
      end else n_chk++;
      check("R11", irq_o, m_irq);
      check("R8", tx_resume_o, m_resume);
    end
  end

  always @(posedge clk_i) begin
    cyc_cnt++;
    if (cyc_cnt > 20000 && !done) begin
      n_err++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc_cnt);
      finish_run();
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_we_i = 1; reg_addr_i = a; reg_wdata_i = d;
    cyc(1);
    reg_we_i = 0; reg_addr_i = 0; reg_wdata_i = 0;
  endtask

  // ---------------- directed stimulus ----------------
  initial begin
    cyc(3);
    rst_ni = 1;
    cyc(1);
    check("R1 reset status", reg_rdata_o, 8'h80);
    check("R1 reset irq", irq_o, 0);
    reg_addr_i = 1; #0.5;
    check("R1 reset enables", reg_rdata_o, 0);
    reg_addr_i = 0;

    ev_msg_ready_i = 1; cyc(1); ev_msg_ready_i = 0;
    check("R12 msg ready set", reg_rdata_o[5], 1);

    wr(0, 8'h00);
    check("R2 zero write keeps flag", reg_rdata_o[5], 1);
    wr(0, 8'h20);
    check("R2 w1c clears", reg_rdata_o[5], 0);

    ev_msg_ready_i = 1; wr(0, 8'h20); ev_msg_ready_i = 0;
    check("R3 set beats clear", reg_rdata_o[5], 1);

    init_mode_i = 1; ev_msg_ready_i = 1; ev_rx_done_i = 1;
    cyc(1);
    check("R4 init forces zero", reg_rdata_o[5:0], 0);
    cyc(1);
    check("R4 init holds zero", reg_rdata_o[5:0], 0);
    init_mode_i = 0; ev_msg_ready_i = 0; ev_rx_done_i = 0;

    ev_rx_done_i = 1; ev_bit_err_i = 1; cyc(1);
    check("R5 bit error blocks rx done", reg_rdata_o[0], 0);
    ev_bit_err_i = 0; ev_frame_err_i = 1; cyc(1);
    check("R5 framing error blocks rx done", reg_rdata_o[0], 0);
    ev_frame_err_i = 0; cyc(1); ev_rx_done_i = 0;
    check("R5 clean rx done sets", reg_rdata_o[0], 1);
    wr(0, 8'h01);

    ev_tx_done_i = 1; ev_bit_err_i = 1; cyc(1);
    check("R6 bit error blocks tx done", reg_rdata_o[1], 0);
    ignore_bit_err_i = 1; cyc(1);
    ev_tx_done_i = 0; ev_bit_err_i = 0; ignore_bit_err_i = 0;
    check("R6 ignored bit error sets tx done", reg_rdata_o[1], 1);
    wr(0, 8'h02);

    dfl_i = 7; ev_buf_full_i = 1; ev_buf_empty_i = 1; cyc(1);
    check("R7 short frame no buffer flags", reg_rdata_o[3:2], 0);
    dfl_i = 8; cyc(1);
    check("R7 long frame buffer flags", reg_rdata_o[3:2], 2'b11);
    ev_buf_full_i = 0; ev_buf_empty_i = 0; dfl_i = 15;
    wr(0, 8'h04);
    check("R8 no resume on full clear", tx_resume_o, 0);

    wr(0, 8'h08);
    check("R8 buffer empty cleared", reg_rdata_o[3], 0);
    check("R8 resume pulse", tx_resume_o, 1);
    cyc(1);
    check("R8 resume one cycle", tx_resume_o, 0);

    slave_mode_i = 1; sleep_i = 0;
    rx_pin_i = 0; cyc(4);
    check("R9 awake slave ignores edge", reg_rdata_o[4], 0);
    rx_pin_i = 1; cyc(3);
    sleep_i = 1; rx_pin_i = 0;
    cyc(1);
    check("R10 pin not yet visible", reg_rdata_o[7], 1);
    cyc(1);
    check("R10 pin after two edges", reg_rdata_o[7], 0);
    check("R9 flag not before third edge", reg_rdata_o[4], 0);
    cyc(1);
    check("R9 sleeping slave wakes", reg_rdata_o[4], 1);
    rx_pin_i = 1; cyc(3); wr(0, 8'h10);

    slave_mode_i = 0; sleep_i = 0; master_idle_i = 0;
    rx_pin_i = 0; cyc(4);
    check("R9 active master ignores edge", reg_rdata_o[4], 0);
    rx_pin_i = 1; cyc(3);
    master_idle_i = 1; rx_pin_i = 0; cyc(3);
    check("R9 idle master wakes", reg_rdata_o[4], 1);
    rx_pin_i = 1; master_idle_i = 0; cyc(3);

    rx_busy_i = 1; #0.5;
    check("R10 busy live", reg_rdata_o[6], 1);
    rx_busy_i = 0; #0.5;
    check("R10 busy drops", reg_rdata_o[6], 0);

    wr(1, 8'h10);
    check("R11 irq not yet", irq_o, 0);
    reg_addr_i = 1; #0.5;
    check("R11 enable readback", reg_rdata_o, 8'h10);
    reg_addr_i = 0;
    cyc(1);
    check("R11 irq raised", irq_o, 1);
    wr(0, 8'h10);
    check("R11 irq still one edge behind", irq_o, 1);
    cyc(1);
    check("R11 irq dropped", irq_o, 0);
    ev_msg_ready_i = 1; cyc(1); ev_msg_ready_i = 0; cyc(2);
    check("R11 disabled flag no irq", irq_o, 0);

    cyc(2);
    finish_run();
  end
endmodule